// File: doc/BRIEF.md
# Fault Status Flags and Interrupt Controller

This block collects six fault indications from a clock device and presents them to software. Five are loss-of-signal detectors: three clock inputs, the crystal input and the feedback input. The sixth is loss of lock of the PLL. Each source has a live status bit that follows the synchronized input, a sticky flag that records any change of that status, and a mask bit that decides whether the flag may raise the interrupt.

The fault inputs are asynchronous. Each passes through a two-stage synchronizer before edge detection. A rising or a falling edge of the synchronized status sets the flag. Software clears a flag by writing a zero to it. Writing a one leaves the flag as it is. When a set and a clear hit the same flag in the same cycle, the set takes effect.

The active-low interrupt is the registered OR of all unmasked flags. It returns high once software has cleared those flags. The synchronized loss-of-lock status also drives a dedicated active-low pin. Software reaches three registers over a simple address/data bus. Reads return data one cycle after the request.

Top module: `fault_flag_irq`

## Requirements
- R1: After reset all flags read 0, the mask register reads 0x3F (every source masked), live status reads 0, and `irq_n` and `lol_n` are both 1.
- R2: Address 0 returns the live status. Each bit follows its fault input within four clock cycles. Bit 0 is input 0, bit 1 is input 1, bit 2 is input 2, bit 3 is the crystal input, bit 4 is the feedback input and bit 5 is loss of lock. Writes to address 0 have no effect.
- R3: Address 1 returns the sticky flags, with the same bit order as R2. A flag sets on a rising or a falling edge of its synchronized status and stays set until it is cleared.
- R4: A write to address 1 clears every flag whose data bit is 0 and leaves unchanged every flag whose data bit is 1.
- R5: If a flag's set event and a clearing write occur in the same cycle, the flag is set afterwards.
- R6: `irq_n` is 0 on the cycle after any flag is set while its mask bit is 0. It returns to 1 once no unmasked flag remains.
- R7: Address 2 holds the mask bits and is readable and writable. A source whose mask bit is 1 never drives `irq_n` low.
- R8: `lol_n` is the inverse of the synchronized loss-of-lock status (R2 bit 5).
- R9: A read request gives `bus_rvalid` high on the next cycle with the data. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_in | input | 6 | Asynchronous fault indications, bit order as in R2 |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 6 | Write data |
| bus_rdata | output | 6 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_n | output | 1 | Active-low interrupt |
| lol_n | output | 1 | Active-low loss-of-lock output |

## Verification
Some behaviours are checked by assertions on every cycle:
- Flags hold unless a write clears them.
- A zero written to a flag clears it when no set event arrives in the same cycle.
- A set event wins over a clear.
- The interrupt follows the unmasked flags one cycle later.
- The unused address reads as zero.

The bench scenarios show the rest:
- The bit order of the sources.
- The synchronizer delay.
- That a falling status also sets a flag.
- That writes to the live status register are ignored.
- The reset values.
- The exact cycle alignment in which a set event meets a clearing write.

// File: rtl/fltirq_pkg.sv
// Package: shared constants and the register selector for the fault
// status and interrupt block.
package fltirq_pkg;
    localparam int unsigned NSRC   = 6;
    localparam int unsigned ADDR_W = 2;
    localparam int unsigned SYNC_N = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LIVE   = 2'd0,
        SEL_STICKY = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/fault_sync.sv
// fault_sync: a multi-stage synchronizer per fault input, followed by an edge
// detector. Assumes each raw input is asynchronous and holds for longer than
// one clock. The change output pulses for one cycle on either edge of the
// synchronized level.
module fault_sync #(
    parameter int unsigned N      = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] level,
    output logic [N-1:0] change
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][N-1:0] pipe;
    logic [N-1:0]             level_d;

    // shift the raw inputs through the synchronizer stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= raw;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    // keep last cycle's synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= '0;
        else        level_d <= pipe[LAST];
    end

    assign level  = pipe[LAST];
    assign change = pipe[LAST] ^ level_d;
endmodule

// File: rtl/flag_bank.sv
// flag_bank: one sticky flag per source. A set event raises the flag. A write
// with clr_en clears the flags whose keep bit is zero. A set event in the same
// cycle as a clear leaves the flag set.
module flag_bank #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic         clr_en,
    input  logic [N-1:0] clr_keep,
    output logic [N-1:0] flags
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_flag
            // update one sticky bit: a set event overrides a clear
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flags[i] <= 1'b0;
                else if (set_evt[i])
                    flags[i] <= 1'b1;
                else if (clr_en && !clr_keep[i])
                    flags[i] <= 1'b0;
            end

            // R3
            flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (flags[i] && !(clr_en && !clr_keep[i])) |=> flags[i]);

            // R4
            flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_en && !clr_keep[i] && !set_evt[i]) |=> !flags[i]);

            // R5
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_evt[i] |=> flags[i]);
        end
    endgenerate
endmodule

// File: rtl/reg_port.sv
// reg_port: the register access side. It holds the masks (reset all ones),
// turns writes to the flag address into a clear request, and returns
// registered read data one cycle after a read strobe.
module reg_port #(
    parameter int unsigned N = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [fltirq_pkg::ADDR_W-1:0] addr,
    input  logic                          wr,
    input  logic                          rd,
    input  logic [N-1:0]                  wdata,
    input  logic [N-1:0]                  status,
    input  logic [N-1:0]                  flags,
    output logic [N-1:0]                  mask,
    output logic                          clr_en,
    output logic [N-1:0]                  clr_keep,
    output logic [N-1:0]                  rdata,
    output logic                          rvalid
);
    import fltirq_pkg::*;

    reg_sel_e     sel;
    logic [N-1:0] rd_mux;

    assign sel = reg_sel_e'(addr);

    // raise a clear request for writes to the sticky flag register
    always_comb begin
        clr_en   = wr && (sel == SEL_STICKY);
        clr_keep = wdata;
    end

    // mask register, all sources masked after reset
    always_ff @(posedge clk) begin
        if (!rst_n)                      mask <= '1;
        else if (wr && sel == SEL_MASK)  mask <= wdata;
    end

    // select the register being read
    always_comb begin
        unique case (sel)
            SEL_LIVE:   rd_mux = status;
            SEL_STICKY: rd_mux = flags;
            SEL_MASK:   rd_mux = mask;
            default:    rd_mux = '0;
        endcase
    end

    // register the read data and its valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd) rdata <= rd_mux;
        end
    end

    // R9
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_SPARE) |=> (rvalid && rdata == '0));
endmodule

// File: rtl/irq_merge.sv
// irq_merge: registered OR over the unmasked flags, driven active low.
module irq_merge #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] mask,
    output logic         irq_n
);
    logic pending;

    assign pending = |(flags & ~mask);

    // register the combined request, idle high
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= ~pending;
    end
endmodule

// File: rtl/fault_flag_irq.sv
// fault_flag_irq: top of the fault status and interrupt block. Assumes
// fault_in is asynchronous, with bit order: input 0, input 1, input 2,
// crystal input, feedback input, loss of lock. The loss-of-lock pin follows
// the synchronized status.
module fault_flag_irq #(
    parameter int unsigned NSRC    = fltirq_pkg::NSRC,
    parameter int unsigned STAGES  = fltirq_pkg::SYNC_N,
    parameter int unsigned LOL_BIT = NSRC - 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NSRC-1:0]               fault_in,
    input  logic [fltirq_pkg::ADDR_W-1:0] bus_addr,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [NSRC-1:0]               bus_wdata,
    output logic [NSRC-1:0]               bus_rdata,
    output logic                          bus_rvalid,
    output logic                          irq_n,
    output logic                          lol_n
);
    logic [NSRC-1:0] status;
    logic [NSRC-1:0] change;
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] mask;
    logic [NSRC-1:0] clr_keep;
    logic            clr_en;

    fault_sync #(.N(NSRC), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(fault_in),
        .level(status), .change(change)
    );

    flag_bank #(.N(NSRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_evt(change),
        .clr_en(clr_en), .clr_keep(clr_keep), .flags(flags)
    );

    reg_port #(.N(NSRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .status(status), .flags(flags), .mask(mask),
        .clr_en(clr_en), .clr_keep(clr_keep), .rdata(bus_rdata),
        .rvalid(bus_rvalid)
    );

    irq_merge #(.N(NSRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .flags(flags), .mask(mask), .irq_n(irq_n)
    );

    // drive the dedicated loss-of-lock pin from the synchronized status
    always_comb lol_n = ~status[LOL_BIT];

    // R6
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & ~mask)) |=> !irq_n);

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~mask) == '0) |=> irq_n);
endmodule

// File: tb/fault_flag_irq_test.sv
module fault_flag_irq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] fault_in = '0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [5:0] bus_wdata = '0;
    logic [5:0] bus_rdata;
    logic       bus_rvalid;
    logic       irq_n;
    logic       lol_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [5:0] data;
        string      req;
    } exp_t;
    exp_t sb[$];

    fault_flag_irq uut (
        .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_n(irq_n),
        .lol_n(lol_n)
    );

    always #2 clk = ~clk;

    // monitor: compare each returned read against the scoreboard
    always @(negedge clk) begin
        if (bus_rvalid) begin
            n_checks++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R9: unexpected read data %h, expected none", bus_rdata);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (bus_rdata !== e.data) begin
                    n_fail++;
                    $display("FAIL %s: read %h, expected %h", e.req, bus_rdata, e.data);
                end
            end
        end
    end

    task automatic rd(input logic [1:0] a, input logic [5:0] exp, input string req);
        exp_t e;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        e.data = exp; e.req = req;
        sb.push_back(e);
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b, expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk(irq_n, 1'b1, "R1 irq_n");
        chk(lol_n, 1'b1, "R1 lol_n");
        rd(2'd0, 6'h00, "R1 status");
        rd(2'd1, 6'h00, "R1 flags");
        rd(2'd2, 6'h3F, "R1 mask");

        // R2/R3 input 0 rises, masked
        fault_in = 6'b000001; settle();
        rd(2'd0, 6'h01, "R2 status in0");
        rd(2'd1, 6'h01, "R3 flag on rise");
        chk(irq_n, 1'b1, "R7 masked flag");

        // R6 unmask source 0
        wr(2'd2, 6'h3E); settle();
        rd(2'd2, 6'h3E, "R7 mask readback");
        chk(irq_n, 1'b0, "R6 unmasked flag");

        // R4 writing ones keeps flags
        wr(2'd1, 6'h3F); settle();
        rd(2'd1, 6'h01, "R4 ones keep");
        chk(irq_n, 1'b0, "R4 irq kept");

        // R4/R6 clear with zero
        wr(2'd1, 6'h3E); settle();
        rd(2'd1, 6'h00, "R4 zero clears");
        chk(irq_n, 1'b1, "R6 irq released");

        // R3 falling edge sets again
        fault_in = 6'b000000; settle();
        rd(2'd1, 6'h01, "R3 flag on fall");
        chk(irq_n, 1'b0, "R6 irq on fall");
        wr(2'd1, 6'h00); settle();

        // R2 write to live status ignored; R9 spare reads zero
        wr(2'd0, 6'h3F); settle();
        rd(2'd0, 6'h00, "R2 write ignored");
        rd(2'd3, 6'h00, "R9 spare zero");

        // R8 loss of lock pin, masked source
        fault_in = 6'b100000; settle();
        chk(lol_n, 1'b0, "R8 lol asserted");
        rd(2'd0, 6'h20, "R2 status lol bit");
        chk(irq_n, 1'b1, "R7 masked lol");
        fault_in = 6'b000000; settle();
        chk(lol_n, 1'b1, "R8 lol released");

        // R5 set event coincides with clearing write
        @(negedge clk); fault_in[1] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_addr = 2'd1; bus_wdata = 6'h00; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        settle();
        rd(2'd1, 6'h02, "R5 set wins");

        // R2/R6 several sources, all unmasked
        wr(2'd1, 6'h00);
        wr(2'd2, 6'h00);
        fault_in = 6'b011110; settle();
        rd(2'd0, 6'h1E, "R2 multi status");
        rd(2'd1, 6'h1C, "R3 multi flags");
        chk(irq_n, 1'b0, "R6 multi irq");
        wr(2'd1, 6'h00); settle();
        chk(irq_n, 1'b1, "R6 all cleared");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R9: %0d reads missing, expected 0", sb.size());
        end
        finish_run();
    end
endmodule